// File: doc/BRIEF.md
# Filtered scanline interrupt counter

This block raises a CPU interrupt after a fixed number of qualified rising edges on video address line 12. During rendering, a rising edge on that line marks each scanline. The edge filter counts CPU clock-enable ticks while the line is low. It accepts a rise only after the line has stayed low for a minimum number of ticks, so that short glitches inside a scanline are ignored. Each accepted rise steps a small counter. The counter reloads a fixed constant when it is empty or when reloading has been requested. Otherwise it decrements.

Software controls the block through two decoded write strobes. The arm strobe empties the counter, requests a reload and enables the interrupt. The acknowledge strobe disables the interrupt and clears any pending request. The request is a level that stays high until it is acknowledged. Because the first accepted rise after arming only reloads the counter, the interrupt fires on the (reload + 1)-th accepted rise.

Top module: `scanline_irq_counter`

## Requirements
- R1: A rise of `a12_i` (high in this cycle, low in the previous one) is accepted only if `a12_i` was low for at least LOW_TICKS (default 3) `cpu_tick_i` pulses before it went high. A rise after fewer ticks has no effect on the count.
- R2: On an accepted rise, the counter loads RELOAD_VAL (default 7) and clears the reload request if the counter is 0 or a reload is requested. Otherwise it decrements by one. Re-arming part-way through a count therefore restarts the full count.
- R3: `irq_o` rises only on an accepted rise while the interrupt is enabled and the counter steps from 1 to 0.
- R4: A pulse on `arm_wr_i` clears the counter, requests a reload and enables the interrupt. Counting from arming, `irq_o` is 0 after each of the first RELOAD_VAL accepted rises and is 1 after rise number RELOAD_VAL + 1.
- R5: A pulse on `ack_wr_i` disables the interrupt and clears `irq_o`. In a cycle where it coincides with `arm_wr_i` or with an accepted rise, the acknowledge takes precedence and the other event has no effect.
- R6: Once high, `irq_o` stays high until `ack_wr_i` is pulsed. Arming and further rises leave it high.
- R7: While the interrupt is disabled, no number of accepted rises raises `irq_o`.
- R8: Reset clears the counter, the reload request, the enable, the pending request and the filter's tick count. The line level sampled at reset is treated as high, so reset never produces an accepted rise.
- R9: The low period is measured in `cpu_tick_i` pulses, not in clock cycles. A line held low for many clocks that contain fewer than LOW_TICKS ticks does not qualify its next rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick_i | input | 1 | CPU clock-enable, one pulse per CPU cycle |
| a12_i | input | 1 | Video address line 12, synchronous to `clk` |
| arm_wr_i | input | 1 | Decoded write strobe: arm and request reload |
| ack_wr_i | input | 1 | Decoded write strobe: disable and acknowledge |
| irq_o | output | 1 | Interrupt request level, active high |

## Verification
The rise is judged at the clock edge that first samples `a12_i` high, and any resulting change to `irq_o` is registered at that same edge. The request is therefore due one clock after the rising level is driven. The strobes also act at the next clock edge. The bench drives every input on a falling edge and reads `irq_o` on the falling edge that follows the active edge in question, so that each sample falls halfway between the edge that produced the value and the next one. Tick counts for the filter are built one tick per clock from the same falling edges, which lets the bench compute exactly how many ticks the block has seen before each rise.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD   = 2'd0,
      STEP_RELOAD = 2'd1,
      STEP_DEC    = 2'd2
   } step_e;

   function automatic int unsigned width_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/sirq_a12_filter.sv
module sirq_a12_filter #(
   parameter int unsigned LOW_TICKS = 3,
   localparam int unsigned LW = scanline_irq_pkg::width_for(LOW_TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_tick_i,
   input  logic          a12_i,
   output logic          edge_o,
   output logic [LW-1:0] low_cnt_o
);
   logic a12_prev_q;
   logic rise;

   always_ff @(posedge clk) begin
      if (!rst_n) a12_prev_q <= 1'b1;
      else        a12_prev_q <= a12_i;
   end

   assign rise = a12_i & ~a12_prev_q;

   generate
      if (LOW_TICKS == 0) begin : g_nofilt
         assign edge_o    = rise;
         assign low_cnt_o = '0;
      end else begin : g_filt
         localparam logic [LW-1:0] SAT = LW'(LOW_TICKS);
         logic [LW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (a12_i)                   cnt_q <= '0;
            else if (cpu_tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
         end
         assign edge_o    = rise && (cnt_q == SAT);
         assign low_cnt_o = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
   parameter int unsigned RELOAD_VAL = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic arm_i,
   input  logic ack_i,
   output logic en_o,
   output logic irq_o
);
   import scanline_irq_pkg::*;
   localparam int unsigned CW = width_for(RELOAD_VAL);
   localparam logic [CW-1:0] RLD = CW'(RELOAD_VAL);

   generate
      if (RELOAD_VAL < 1) begin : g_bad_reload
         $error("sirq_counter: RELOAD_VAL must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q, cnt_nxt;
   logic          reload_q, en_q, pend_q;
   step_e         step;
   logic          fire;

   always_comb begin
      if (!edge_i)                       step = STEP_HOLD;
      else if (cnt_q == '0 || reload_q)  step = STEP_RELOAD;
      else                               step = STEP_DEC;
      case (step)
         STEP_RELOAD: cnt_nxt = RLD;
         STEP_DEC:    cnt_nxt = cnt_q - 1'b1;
         default:     cnt_nxt = cnt_q;
      endcase
      fire = en_q && (cnt_nxt == '0) &&
             ((step == STEP_DEC && cnt_q == CW'(1)) || step == STEP_RELOAD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= 1'b0;
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
      end else if (ack_i) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (arm_i) begin
         cnt_q    <= '0;
         reload_q <= 1'b1;
         en_q     <= 1'b1;
      end else if (step != STEP_HOLD) begin
         cnt_q    <= cnt_nxt;
         reload_q <= 1'b0;
         if (fire) pend_q <= 1'b1;
      end
   end

   assign en_o  = en_q;
   assign irq_o = pend_q;
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
   parameter int unsigned LOW_TICKS  = 3,
   parameter int unsigned RELOAD_VAL = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_tick_i,
   input  logic a12_i,
   input  logic arm_wr_i,
   input  logic ack_wr_i,
   output logic irq_o
);
   localparam int unsigned LW = scanline_irq_pkg::width_for(LOW_TICKS);

   logic          qual_edge;
   logic [LW-1:0] low_cnt;
   logic          irq_en;

   sirq_a12_filter #(.LOW_TICKS(LOW_TICKS)) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_tick_i (cpu_tick_i),
      .a12_i      (a12_i),
      .edge_o     (qual_edge),
      .low_cnt_o  (low_cnt)
   );

   sirq_counter #(.RELOAD_VAL(RELOAD_VAL)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (qual_edge),
      .arm_i  (arm_wr_i),
      .ack_i  (ack_wr_i),
      .en_o   (irq_en),
      .irq_o  (irq_o)
   );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
   parameter int unsigned LOW_TICKS = 3,
   parameter int unsigned LW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a12_i,
   input logic          arm_wr_i,
   input logic          ack_wr_i,
   input logic          irq_o,
   input logic          qual_edge,
   input logic [LW-1:0] low_cnt,
   input logic          irq_en
);
   AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      qual_edge |-> (a12_i && low_cnt == LW'(LOW_TICKS))); // R1
   AST_QUAL_WAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      qual_edge |-> !$past(a12_i)); // R1
   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(qual_edge) && $past(irq_en) && !$past(ack_wr_i))); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr_i |=> (!irq_o && !irq_en)); // R5
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_wr_i) |=> irq_o); // R6
   AST_ARM_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr_i && !ack_wr_i) |=> irq_en); // R4
   AST_NO_RISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !arm_wr_i) |=> !$rose(irq_o)); // R7
endmodule

bind scanline_irq_counter sirq_checker #(.LOW_TICKS(LOW_TICKS), .LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .a12_i     (a12_i),
   .arm_wr_i  (arm_wr_i),
   .ack_wr_i  (ack_wr_i),
   .irq_o     (irq_o),
   .qual_edge (qual_edge),
   .low_cnt   (low_cnt),
   .irq_en    (irq_en)
);

// File: tb/scanline_irq_counter_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb_top;
   localparam int LOW  = 3;
   localparam int RLD  = 7;
   localparam int FIRE = RLD + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_tick = 1'b0;
   logic a12 = 1'b1;
   logic arm = 1'b0;
   logic ack = 1'b0;
   logic irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   scanline_irq_counter #(.LOW_TICKS(LOW), .RELOAD_VAL(RLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_tick_i(cpu_tick), .a12_i(a12),
      .arm_wr_i(arm), .ack_wr_i(ack), .irq_o(irq)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: irq_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // low phase with idle clocks and ticks, then rise; returns at the sample point
   task automatic line(input int ticks, input int idle, input logic ack_at_rise);
      @(negedge clk); a12 = 1'b0; cpu_tick = 1'b0;
      for (int i = 0; i < idle; i++) @(negedge clk);
      for (int i = 0; i < ticks; i++) begin
         cpu_tick = 1'b1; @(negedge clk);
      end
      cpu_tick = 1'b0; a12 = 1'b1; ack = ack_at_rise;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic strobe(input logic do_arm, input logic do_ack);
      @(negedge clk); arm = do_arm; ack = do_ack;
      @(negedge clk); arm = 1'b0; ack = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset state", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after release", irq, 1'b0);

      // R4 R2 R3: count from arm
      strobe(1'b1, 1'b0);
      for (int k = 1; k <= FIRE + 2; k++) begin
         line(LOW, 0, 1'b0);
         check("R4 edge count", irq, logic'(k >= FIRE));
      end

      // R2: re-arm mid count restarts full count
      strobe(1'b0, 1'b1);
      strobe(1'b1, 1'b0);
      for (int k = 0; k < 5; k++) line(LOW, 0, 1'b0);
      strobe(1'b1, 1'b0);
      for (int k = 1; k <= FIRE; k++) begin
         line(LOW, 0, 1'b0);
         check("R2 rearm restart", irq, logic'(k == FIRE));
      end

      // R1 filter sweep over tick counts before the final rise
      for (int t = 0; t <= LOW + 2; t++) begin
         strobe(1'b0, 1'b1);
         strobe(1'b1, 1'b0);
         for (int k = 0; k < RLD; k++) line(LOW, 0, 1'b0);
         check("R1 before last rise", irq, 1'b0);
         line(t, 0, 1'b0);
         check("R1 filter ticks", irq, logic'(t >= LOW));
      end

      // R9: long low time with too few ticks
      strobe(1'b0, 1'b1);
      strobe(1'b1, 1'b0);
      for (int k = 0; k < RLD; k++) line(LOW, 0, 1'b0);
      line(LOW - 1, 12, 1'b0);
      check("R9 clocks are not ticks", irq, 1'b0);
      line(LOW, 0, 1'b0);
      check("R9 proper rise fires", irq, 1'b1);

      // R7: disabled, many rises
      strobe(1'b0, 1'b1);
      for (int k = 0; k < 2 * FIRE; k++) begin
         line(LOW, 0, 1'b0);
         check("R7 disabled", irq, 1'b0);
      end

      // R5: ack on the firing rise wins
      strobe(1'b1, 1'b0);
      for (int k = 0; k < RLD; k++) line(LOW, 0, 1'b0);
      line(LOW, 0, 1'b1);
      check("R5 ack beats rise", irq, 1'b0);
      for (int k = 0; k < FIRE; k++) line(LOW, 0, 1'b0);
      check("R5 stays disabled", irq, 1'b0);
      // R5: arm and ack together -> disabled
      strobe(1'b1, 1'b1);
      for (int k = 0; k < FIRE + 1; k++) line(LOW, 0, 1'b0);
      check("R5 ack beats arm", irq, 1'b0);

      // R6: sticky level
      strobe(1'b1, 1'b0);
      for (int k = 0; k < FIRE; k++) line(LOW, 0, 1'b0);
      check("R6 fired", irq, 1'b1);
      strobe(1'b1, 1'b0);
      check("R6 arm keeps level", irq, 1'b1);
      for (int k = 0; k < 3; k++) line(LOW, 0, 1'b0);
      check("R6 rises keep level", irq, 1'b1);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      check("R6 ack drops level", irq, 1'b0);

      // R8: reset with pending request and line high
      strobe(1'b1, 1'b0);
      for (int k = 0; k < FIRE; k++) line(LOW, 0, 1'b0);
      check("R8 pending before reset", irq, 1'b1);
      @(negedge clk); rst_n = 1'b0; a12 = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 reset clears", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 no edge at release", irq, 1'b0);
      strobe(1'b1, 1'b0);
      line(1, 0, 1'b0);
      for (int k = 1; k <= FIRE; k++) begin
         line(LOW, 0, 1'b0);
         check("R8 count after reset", irq, logic'(k == FIRE));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule